// File: doc/BRIEF.md
# LCD Frame and Common Timing Generator

This block sequences the back-plane (common) lines of a multiplexed segment LCD and decides the polarity of the drive waveform. It runs on the system clock and takes two single-cycle enable strobes, one at 2048 Hz and one at 128 Hz. A select input picks which strobe acts as the LCD clock. A frame divider counts the chosen strobes and produces one step per divider period. At each step the active common index moves to the next common line. When the index wraps back to line 0, the polarity flag inverts. Over one frame every common is therefore driven once in each polarity, and the waveform carries no net DC.

The common count comes from a two-bit multiplex field, from static drive (one common) up to four commons. A four-bit divider field sets the step period. With the 128 Hz clock this field is clamped to its fastest usable values. The segment drivers use the active common index and the polarity flag to build their levels. A single-cycle frame-start pulse marks the moment common 0 becomes active in positive polarity, so downstream logic can latch new segment data on a frame boundary. Any change of clock select, multiplex or divider setting restarts the sequence cleanly.

Top module: `lcd_tg_top`

## Requirements
- R1: With `fast_sel`=1 only `tick_2k` advances the divider, and with `fast_sel`=0 only `tick_128` advances it. The other strobe has no effect on any output.
- R2: The number of commons is `mux_mode`+1: 2'b00 is static (1 common), 2'b01 is 2, 2'b10 is 3 and 2'b11 is 4. Successive steps drive `com_idx` through 0,1,…,N-1 and then back to 0.
- R3: With the 2048 Hz clock, a step occurs on every 2×(`frame_div`+1)-th selected strobe.
- R4: With the 128 Hz clock, a step occurs on every (min(`frame_div`,3)+1)-th selected strobe. Divider values above 3 behave as 3.
- R5: `invert` toggles exactly on those steps where `com_idx` wraps from N-1 to 0. In every other case it holds its value. With static drive it therefore toggles on every step.
- R6: `frame_start` is high for exactly one system clock, in the cycle after the step that makes common 0 active with `invert`=0. It is low at all other times.
- R7: A change of `fast_sel`, `mux_mode` or `frame_div` clears the divider count, and a strobe arriving in the same cycle is not counted. Outputs hold until the next step, which sets `com_idx`=0 and `invert`=0 and pulses `frame_start`.
- R8: While `rst_n` is low, `com_idx`=0, `invert`=0 and `frame_start`=0. The first step after reset behaves like the restart of R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_2k | input | 1 | One-cycle enable strobe at 2048 Hz |
| tick_128 | input | 1 | One-cycle enable strobe at 128 Hz |
| fast_sel | input | 1 | 1 selects the 2048 Hz LCD clock, 0 the 128 Hz clock |
| mux_mode | input | 2 | Multiplex level, number of commons minus one |
| frame_div | input | 4 | Frame divider setting |
| com_idx | output | 2 | Index of the active common line |
| invert | output | 1 | Drive polarity, 1 = inverted half of the frame |
| frame_start | output | 1 | One-cycle pulse at the start of each frame |

## Verification
The hardest situation to reach from the ports is a configuration change that lands in the same cycle as a selected strobe, in the middle of a frame. The bench raises a strobe and changes the divider on the same clock edge partway through a four-common sequence. It then checks that the outputs hold and that the new period is counted from zero. It also confirms that the step after the change lands on common 0 in positive polarity with a frame-start pulse. The unselected strobe is held high for entire vectors, so any leak into the divider shows up as an early step.

// File: rtl/lcd_tg_pkg.sv
package lcd_tg_pkg;

    localparam int DIV_W    = 4;
    localparam int MUX_W    = 2;
    localparam int COM_W    = 2;
    localparam int SLOW_MAX = 3;

    typedef struct packed {
        logic             fast;
        logic [MUX_W-1:0] mux;
        logic [DIV_W-1:0] div;
    } lcd_cfg_t;

endpackage

// File: rtl/lcd_tg_src.sv
module lcd_tg_src #(
    parameter int DIV_W    = lcd_tg_pkg::DIV_W,
    parameter int SLOW_MAX = lcd_tg_pkg::SLOW_MAX,
    localparam int PER_W   = DIV_W + 2
) (
    input  logic             tick_2k,
    input  logic             tick_128,
    input  logic             fast_sel,
    input  logic [DIV_W-1:0] frame_div,
    output logic             tick_sel,
    output logic [PER_W-1:0] period
);

    logic [DIV_W-1:0] div_slow;

    always_comb begin
        if (32'(frame_div) > SLOW_MAX) begin
            div_slow = DIV_W'(SLOW_MAX);
        end else begin
            div_slow = frame_div;
        end
    end

    always_comb begin
        if (fast_sel) begin
            tick_sel = tick_2k;
            period   = (PER_W'(frame_div) + PER_W'(1)) << 1;
        end else begin
            tick_sel = tick_128;
            period   = PER_W'(div_slow) + PER_W'(1);
        end
    end

endmodule

// File: rtl/lcd_tg_div.sv
module lcd_tg_div #(
    parameter int PER_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clear,
    input  logic [PER_W-1:0] period,
    output logic             step
);

    logic [PER_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        step  = 1'b0;
        if (clear) begin
            cnt_d = '0;
        end else if (tick) begin
            if (cnt_q + PER_W'(1) >= period) begin
                cnt_d = '0;
                step  = 1'b1;
            end else begin
                cnt_d = cnt_q + PER_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/lcd_tg_seq.sv
module lcd_tg_seq #(
    parameter int COM_W = lcd_tg_pkg::COM_W,
    parameter int MUX_W = lcd_tg_pkg::MUX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             restart,
    input  logic [MUX_W-1:0] mux_mode,
    output logic [COM_W-1:0] com_idx,
    output logic             invert,
    output logic             frame_start
);

    typedef struct packed {
        logic [COM_W-1:0] com;
        logic             inv;
        logic             fs;
        logic             pend;
    } seq_st_t;

    seq_st_t st_d, st_q;
    logic [COM_W-1:0] last_com;

    assign last_com = COM_W'(mux_mode);

    always_comb begin
        st_d      = st_q;
        st_d.fs   = 1'b0;
        if (restart) begin
            st_d.pend = 1'b1;
        end
        if (step) begin
            if (st_q.pend) begin
                st_d.com  = '0;
                st_d.inv  = 1'b0;
                st_d.fs   = 1'b1;
                st_d.pend = 1'b0;
            end else if (st_q.com >= last_com) begin
                st_d.com = '0;
                st_d.inv = ~st_q.inv;
                st_d.fs  = st_q.inv;
            end else begin
                st_d.com = st_q.com + COM_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{com: '0, inv: 1'b0, fs: 1'b0, pend: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign com_idx     = st_q.com;
    assign invert      = st_q.inv;
    assign frame_start = st_q.fs;

endmodule

// File: rtl/lcd_tg_top.sv
module lcd_tg_top #(
    parameter int DIV_W    = lcd_tg_pkg::DIV_W,
    parameter int MUX_W    = lcd_tg_pkg::MUX_W,
    parameter int COM_W    = lcd_tg_pkg::COM_W,
    parameter int SLOW_MAX = lcd_tg_pkg::SLOW_MAX
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_2k,
    input  logic             tick_128,
    input  logic             fast_sel,
    input  logic [MUX_W-1:0] mux_mode,
    input  logic [DIV_W-1:0] frame_div,
    output logic [COM_W-1:0] com_idx,
    output logic             invert,
    output logic             frame_start
);

    localparam int PER_W = DIV_W + 2;
    localparam int CFG_W = 1 + MUX_W + DIV_W;

    logic [CFG_W-1:0] cfg_now, cfg_d, cfg_q;
    logic             cfg_chg;
    logic             tick_sel;
    logic [PER_W-1:0] period;
    logic             step;

    assign cfg_now = {fast_sel, mux_mode, frame_div};

    always_comb begin
        cfg_d   = cfg_now;
        cfg_chg = (cfg_now != cfg_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    lcd_tg_src #(.DIV_W(DIV_W), .SLOW_MAX(SLOW_MAX)) i_src (
        .tick_2k  (tick_2k),
        .tick_128 (tick_128),
        .fast_sel (fast_sel),
        .frame_div(frame_div),
        .tick_sel (tick_sel),
        .period   (period)
    );

    lcd_tg_div #(.PER_W(PER_W)) i_div (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick_sel),
        .clear (cfg_chg),
        .period(period),
        .step  (step)
    );

    lcd_tg_seq #(.COM_W(COM_W), .MUX_W(MUX_W)) i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (step),
        .restart    (cfg_chg),
        .mux_mode   (mux_mode),
        .com_idx    (com_idx),
        .invert     (invert),
        .frame_start(frame_start)
    );

endmodule

// File: rtl/lcd_tg_chk.sv
module lcd_tg_chk #(
    parameter int MUX_W = 2,
    parameter int COM_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_2k,
    input logic             tick_128,
    input logic             fast_sel,
    input logic [MUX_W-1:0] mux_mode,
    input logic [COM_W-1:0] com_idx,
    input logic             invert,
    input logic             frame_start
);

    logic sel_tick;
    assign sel_tick = fast_sel ? tick_2k : tick_128;

    a_r1_no_step_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_tick |=> ($stable(com_idx) && $stable(invert)));

    a_r2_com_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (com_idx != $past(com_idx)) |-> (com_idx == '0 || com_idx == $past(com_idx) + COM_W'(1)));

    a_r5_flip_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (invert != $past(invert)) |-> (com_idx == '0));

    a_r6_fs_single: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start);

    a_r6_fs_position: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (com_idx == '0 && !invert));

    always_comb begin
        if (!rst_n) begin
            a_r8_reset_state: assert (com_idx == '0 && !invert && !frame_start);
        end
    end

endmodule

bind lcd_tg_top lcd_tg_chk #(.MUX_W(MUX_W), .COM_W(COM_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_2k    (tick_2k),
    .tick_128   (tick_128),
    .fast_sel   (fast_sel),
    .mux_mode   (mux_mode),
    .com_idx    (com_idx),
    .invert     (invert),
    .frame_start(frame_start)
);

// File: tb/test_lcd_tg_top.sv
module test_lcd_tg_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_2k = 1'b0;
    logic       tick_128 = 1'b0;
    logic       fast_sel = 1'b1;
    logic [1:0] mux_mode = 2'b00;
    logic [3:0] frame_div = 4'd0;
    logic [1:0] com_idx;
    logic       invert;
    logic       frame_start;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    lcd_tg_top i_lcd_tg_top (
        .clk(clk), .rst_n(rst_n), .tick_2k(tick_2k), .tick_128(tick_128),
        .fast_sel(fast_sel), .mux_mode(mux_mode), .frame_div(frame_div),
        .com_idx(com_idx), .invert(invert), .frame_start(frame_start)
    );

    // {fast, mux[1:0], div[3:0], expected period[5:0]}
    localparam logic [12:0] VEC [8] = '{
        {1'b1, 2'b11, 4'd0,  6'd2},
        {1'b1, 2'b00, 4'd1,  6'd4},
        {1'b1, 2'b01, 4'd2,  6'd6},
        {1'b1, 2'b10, 4'd15, 6'd32},
        {1'b0, 2'b11, 4'd0,  6'd1},
        {1'b0, 2'b11, 4'd2,  6'd3},
        {1'b0, 2'b10, 4'd9,  6'd4},
        {1'b0, 2'b01, 4'd15, 6'd4}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // one selected strobe, outputs sampled after the edge that saw it
    task automatic pulse();
        if (fast_sel) tick_2k = 1'b1; else tick_128 = 1'b1;
        @(negedge clk);
        if (fast_sel) tick_2k = 1'b0; else tick_128 = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // count per-1 strobes that must not move outputs, then the stepping one
    task automatic step_and_check(input string req, input int per, input int ecom,
                                  input int einv, input int efs);
        logic [1:0] c0;
        logic       i0;
        c0 = com_idx;
        i0 = invert;
        for (int t = 0; t < per - 1; t++) begin
            pulse();
            idle(1);
        end
        check({req, " hold before step"}, {29'd0, com_idx, invert}, {29'd0, c0, i0});
        pulse();
        check({req, " com"}, com_idx, ecom);
        check({req, " invert"}, invert, einv);
        check({req, " frame_start"}, frame_start, efs);
        idle(1);
        check("R6 pulse width", frame_start, 0);
    endtask

    task automatic run_vec(input logic [12:0] v);
        int n, per;
        fast_sel  = v[12];
        mux_mode  = v[11:10];
        frame_div = v[9:6];
        per       = int'(v[5:0]);
        n         = int'(v[11:10]) + 1;
        // hold the unselected strobe high for the whole vector (R1)
        if (v[12]) tick_128 = 1'b1; else tick_2k = 1'b1;
        idle(3);
        for (int k = 0; k < 2 * n + 1; k++) begin
            step_and_check(v[12] ? "R3 R2 R5 R6" : "R4 R1 R2 R5 R6", per,
                           k % n, (k / n) % 2, (k % (2 * n)) == 0);
        end
        tick_2k  = 1'b0;
        tick_128 = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle(4);
        check("R8 reset com", com_idx, 0);
        check("R8 reset invert", invert, 0);
        check("R8 reset frame_start", frame_start, 0);
        rst_n = 1'b1;
        idle(2);
        // first step after reset, default config: restart behaviour (R8)
        step_and_check("R8 first step", 2, 0, 0, 1);

        foreach (VEC[i]) run_vec(VEC[i]);

        // R7: change during a frame, coinciding with a strobe
        fast_sel = 1'b1; mux_mode = 2'b11; frame_div = 4'd0;
        idle(3);
        step_and_check("R7 setup", 2, 0, 0, 1);
        step_and_check("R7 setup", 2, 1, 0, 0);
        step_and_check("R7 setup", 2, 2, 0, 0);
        pulse();                      // one strobe toward the next step
        tick_2k   = 1'b1;
        frame_div = 4'd1;             // change in the same cycle as a strobe
        @(negedge clk);
        tick_2k = 1'b0;
        idle(2);
        check("R7 hold after change com", com_idx, 2);
        check("R7 hold after change invert", invert, 0);
        step_and_check("R7 restart", 4, 0, 0, 1);
        step_and_check("R7 after restart", 4, 1, 0, 0);

        // R4 clamp edge: div=3 and div=4 both give period 4 on the slow clock
        fast_sel = 1'b0; mux_mode = 2'b00; frame_div = 4'd4;
        idle(3);
        step_and_check("R4 clamp", 4, 0, 0, 1);
        step_and_check("R4 clamp static", 4, 0, 1, 0);
        step_and_check("R5 static toggle", 4, 0, 0, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule